// File: doc/BRIEF.md
# Pattern Step Clock Generator

This block paces a pattern sequencer. It turns a chosen timebase into a stream of single-cycle step enables. The timebase is either the system clock or an external clock pin. The block divides that timebase by a ratio taken from setup fields. The pattern engine advances one line for each enable, so the whole chip stays in the system clock domain and no derived clock is needed.

The same setup also decides how a run begins. In one mode a run-button pulse starts the run. In the other mode the block watches a SYNC input for a chosen edge and issues the start pulse itself. A clock-out drive enable asks the pad logic to drive the internal clock onto the external clock pin, so that several units can share one timebase. Both asynchronous inputs pass through a two-flop synchronizer before any edge is detected.

Setup is loaded by a one-cycle write strobe. The write always restarts the divider from zero, so the first step after a change lands at a known distance from the write.

Top module: `pclk_gen`

## Requirements
- R1: While `rst_n` is low, `step_en`, `start_pulse` and `clk_out_en` are low. After reset the setup is: internal source, divide by 1, run-button start, rising SYNC edge, clock-out off. With this setup `step_en` is high on every cycle.
- R2: A cycle with `cfg_wr` high captures all setup fields at that clock edge and clears the divider count. `step_en` is low in the cycle after the write. With ratio N, the first step is seen exactly N clock edges after the write edge.
- R3: With the internal source and ratio N (1 to 1024), `step_en` is a one-cycle pulse every N cycles. With N = 1 it stays high on every cycle.
- R4: A `cfg_div` value above 1024 is treated as a ratio of 1024.
- R5: A `cfg_div` value of 0 selects a ratio of 1,000,000. No step follows within 120,000 cycles of such a write.
- R6: With `cfg_src_ext` = 1, the divider counts rising edges of `ext_clk_in` after the synchronizer, and it issues one step per N such edges.
- R7: `clk_out_en` is high, from the cycle after the write, exactly when `cfg_clk_out` = 1 and `cfg_src_ext` = 0 were written. It is low whenever the external source is selected.
- R8: With `cfg_sync_start` = 0, `start_pulse` is high in the cycle after each cycle in which `run_btn` is high, and `sync_in` has no effect.
- R9: With `cfg_sync_start` = 1 and `cfg_sync_neg` = 0, a rising edge of `sync_in` gives a one-cycle `start_pulse`. The pulse is seen after the third clock edge following the change. A falling edge and `run_btn` have no effect.
- R10: With `cfg_sync_start` = 1 and `cfg_sync_neg` = 1, a falling edge of `sync_in` triggers the pulse with the same latency, and a rising edge has no effect.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_wr | input | 1 | Setup write strobe, one cycle |
| cfg_src_ext | input | 1 | 1: external clock pin is the timebase, 0: system clock |
| cfg_div | input | DIV_W (11) | Ratio field; 0 means 1,000,000, above 1024 clamps to 1024 |
| cfg_sync_start | input | 1 | 1: start on SYNC edge, 0: start on run button |
| cfg_sync_neg | input | 1 | 1: falling SYNC edge is active, 0: rising |
| cfg_clk_out | input | 1 | Request to drive the internal clock out on the external clock pin |
| run_btn | input | 1 | Run request, synchronous to `clk` |
| ext_clk_in | input | 1 | External clock pin, asynchronous |
| sync_in | input | 1 | SYNC trigger input, asynchronous |
| step_en | output | 1 | One-cycle pattern step enable |
| clk_out_en | output | 1 | Drive enable for clock out on the external clock pin |
| start_pulse | output | 1 | One-cycle start trigger |

## Verification
The properties assume that `run_btn` and the setup fields are synchronous to `clk`. They also assume the setup is changed only through `cfg_wr`, and that the sampled SYNC and external clock levels may change at any cycle. The bench drives every input on the falling clock edge, so all of them are stable at the rising edge. It holds the external clock for three system cycles per phase, so no edge is lost in the synchronizer. It changes setup only through single-cycle writes, and it waits for any pending start to leave the synchronizer before it switches the start mode.

// File: rtl/pclk_pkg.sv
package pclk_pkg;

    typedef struct packed {
        logic src_ext;
        logic sync_start;
        logic sync_neg;
        logic clk_out;
    } pclk_mode_t;

    localparam pclk_mode_t PCLK_MODE_RST = '{
        src_ext:    1'b0,
        sync_start: 1'b0,
        sync_neg:   1'b0,
        clk_out:    1'b0
    };

endpackage

// File: rtl/pclk_edge_sync.sv
module pclk_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic din,
    output logic level,
    output logic rise,
    output logic fall
);
    typedef struct packed {
        logic [STAGES:0] sh;
    } sync_st_t;

    sync_st_t st_d, st_q;

    always_comb begin
        st_d    = st_q;
        st_d.sh = {st_q.sh[STAGES-1:0], din};
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level = st_q.sh[STAGES-1];
    assign rise  =  st_q.sh[STAGES-1] & ~st_q.sh[STAGES];
    assign fall  = ~st_q.sh[STAGES-1] &  st_q.sh[STAGES];
endmodule

// File: rtl/pclk_divider.sv
module pclk_divider #(
    parameter int CNT_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear,
    input  logic             tick,
    input  logic [CNT_W-1:0] ratio,
    output logic             step
);
    typedef struct packed {
        logic [CNT_W-1:0] cnt;
        logic             step;
    } div_st_t;

    div_st_t st_d, st_q;

    always_comb begin
        st_d      = st_q;
        st_d.step = 1'b0;
        if (clear) begin
            st_d.cnt = '0;
        end else if (tick) begin
            if (st_q.cnt >= ratio - 1'b1) begin
                st_d.cnt  = '0;
                st_d.step = 1'b1;
            end else begin
                st_d.cnt = st_q.cnt + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign step = st_q.step;
endmodule

// File: rtl/pclk_start.sv
module pclk_start (
    input  logic clk,
    input  logic rst_n,
    input  logic sync_mode,
    input  logic sync_neg,
    input  logic run_btn,
    input  logic sync_rise,
    input  logic sync_fall,
    output logic start
);
    typedef struct packed {
        logic start;
    } start_st_t;

    start_st_t st_d, st_q;

    always_comb begin
        st_d = st_q;
        if (sync_mode) st_d.start = sync_neg ? sync_fall : sync_rise;
        else           st_d.start = run_btn;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign start = st_q.start;
endmodule

// File: rtl/pclk_gen.sv
module pclk_gen #(
    parameter int MAX_DIV     = 1024,
    parameter int SPECIAL_DIV = 1_000_000,
    parameter int SYNC_STAGES = 2,
    localparam int DIV_W      = $clog2(MAX_DIV + 1),
    localparam int CNT_W      = $clog2(SPECIAL_DIV + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             cfg_wr,
    input  logic             cfg_src_ext,
    input  logic [DIV_W-1:0] cfg_div,
    input  logic             cfg_sync_start,
    input  logic             cfg_sync_neg,
    input  logic             cfg_clk_out,
    input  logic             run_btn,
    input  logic             ext_clk_in,
    input  logic             sync_in,
    output logic             step_en,
    output logic             clk_out_en,
    output logic             start_pulse
);
    import pclk_pkg::*;

    localparam logic [DIV_W-1:0] MAX_FIELD = DIV_W'(MAX_DIV);

    typedef struct packed {
        pclk_mode_t       mode;
        logic [CNT_W-1:0] ratio;
        logic             clk_out;
    } gen_st_t;

    gen_st_t          st_d, st_q;
    logic [CNT_W-1:0] ratio_new;
    logic             ext_rise, sync_rise, sync_fall, tick;
    logic             ext_lvl_unused, sync_lvl_unused;
    logic [CNT_W-1:0] ratio_cur;
    logic             sync_mode_cur;

    // field to ratio: 0 is the special long ratio, over-range clamps
    always_comb begin
        if (cfg_div == '0)           ratio_new = CNT_W'(SPECIAL_DIV);
        else if (cfg_div > MAX_FIELD) ratio_new = CNT_W'(MAX_DIV);
        else                         ratio_new = CNT_W'(cfg_div);
    end

    always_comb begin
        st_d = st_q;
        if (cfg_wr) begin
            st_d.mode.src_ext    = cfg_src_ext;
            st_d.mode.sync_start = cfg_sync_start;
            st_d.mode.sync_neg   = cfg_sync_neg;
            st_d.mode.clk_out    = cfg_clk_out;
            st_d.ratio           = ratio_new;
        end
        // never drive the pin while it is our timebase input
        st_d.clk_out = st_d.mode.clk_out & ~st_d.mode.src_ext;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            st_q.mode    <= PCLK_MODE_RST;
            st_q.ratio   <= CNT_W'(1);
            st_q.clk_out <= 1'b0;
        end else begin
            st_q <= st_d;
        end
    end

    pclk_edge_sync #(.STAGES(SYNC_STAGES)) i_ext_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (ext_clk_in),
        .level (ext_lvl_unused),
        .rise  (ext_rise),
        .fall  ()
    );

    pclk_edge_sync #(.STAGES(SYNC_STAGES)) i_trig_sync (
        .clk   (clk),
        .rst_n (rst_n),
        .din   (sync_in),
        .level (sync_lvl_unused),
        .rise  (sync_rise),
        .fall  (sync_fall)
    );

    assign tick = st_q.mode.src_ext ? ext_rise : 1'b1;

    pclk_divider #(.CNT_W(CNT_W)) i_div (
        .clk   (clk),
        .rst_n (rst_n),
        .clear (cfg_wr),
        .tick  (tick),
        .ratio (st_q.ratio),
        .step  (step_en)
    );

    pclk_start i_start (
        .clk       (clk),
        .rst_n     (rst_n),
        .sync_mode (st_q.mode.sync_start),
        .sync_neg  (st_q.mode.sync_neg),
        .run_btn   (run_btn),
        .sync_rise (sync_rise),
        .sync_fall (sync_fall),
        .start     (start_pulse)
    );

    assign clk_out_en    = st_q.clk_out;
    assign ratio_cur     = st_q.ratio;
    assign sync_mode_cur = st_q.mode.sync_start;
endmodule

// File: rtl/pclk_gen_chk.sv
module pclk_gen_chk #(
    parameter int CNT_W = 20
) (
    input logic             clk,
    input logic             rst_n,
    input logic             cfg_wr,
    input logic             cfg_src_ext,
    input logic             run_btn,
    input logic             step_en,
    input logic             clk_out_en,
    input logic             start_pulse,
    input logic [CNT_W-1:0] ratio_cur,
    input logic             sync_mode_cur
);
    p_write_quiet_r2: assert property (@(posedge clk) disable iff (!rst_n)
        cfg_wr |=> !step_en);

    p_step_gap_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (step_en && ratio_cur != CNT_W'(1)) |=> !step_en);

    p_no_drive_ext_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cfg_wr && cfg_src_ext) |=> !clk_out_en);

    p_run_start_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode_cur && run_btn) |=> start_pulse);

    p_run_idle_r8: assert property (@(posedge clk) disable iff (!rst_n)
        (!sync_mode_cur && !run_btn) |=> !start_pulse);
endmodule

bind pclk_gen pclk_gen_chk #(.CNT_W(CNT_W)) i_chk (
    .clk           (clk),
    .rst_n         (rst_n),
    .cfg_wr        (cfg_wr),
    .cfg_src_ext   (cfg_src_ext),
    .run_btn       (run_btn),
    .step_en       (step_en),
    .clk_out_en    (clk_out_en),
    .start_pulse   (start_pulse),
    .ratio_cur     (ratio_cur),
    .sync_mode_cur (sync_mode_cur)
);

// File: tb/test_pclk_gen.sv
module test_pclk_gen;
    localparam int DIV_W = 11;
    localparam int NVEC  = 6;
    localparam int TV_DIV [NVEC] = '{1, 2, 3, 7, 1024, 1500};
    localparam int TV_EXP [NVEC] = '{1, 2, 3, 7, 1024, 1024};
    localparam bit TV_CO  [NVEC] = '{1'b1, 1'b0, 1'b1, 1'b0, 1'b1, 1'b0};

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_wr = 1'b0, cfg_src_ext = 1'b0, cfg_sync_start = 1'b0;
    logic cfg_sync_neg = 1'b0, cfg_clk_out = 1'b0;
    logic [DIV_W-1:0] cfg_div = '0;
    logic run_btn = 1'b0, ext_clk_in = 1'b0, sync_in = 1'b0;
    logic step_en, clk_out_en, start_pulse;
    logic ext_run = 1'b0;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    pclk_gen i_pclk_gen (
        .clk(clk), .rst_n(rst_n), .cfg_wr(cfg_wr), .cfg_src_ext(cfg_src_ext),
        .cfg_div(cfg_div), .cfg_sync_start(cfg_sync_start),
        .cfg_sync_neg(cfg_sync_neg), .cfg_clk_out(cfg_clk_out),
        .run_btn(run_btn), .ext_clk_in(ext_clk_in), .sync_in(sync_in),
        .step_en(step_en), .clk_out_en(clk_out_en), .start_pulse(start_pulse)
    );

    // external clock: three system cycles per phase
    initial begin
        forever begin
            repeat (3) @(negedge clk);
            if (ext_run) ext_clk_in = ~ext_clk_in;
        end
    end

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        total++;
        if (!ok) begin
            bad++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic write_cfg(input bit src, input int div, input bit ss,
                             input bit neg, input bit co);
        @(negedge clk);
        cfg_src_ext = src; cfg_div = DIV_W'(div); cfg_sync_start = ss;
        cfg_sync_neg = neg; cfg_clk_out = co; cfg_wr = 1'b1;
        @(posedge clk);
        @(negedge clk);
        cfg_wr = 1'b0;
    endtask

    // edges until step_en is seen high (sampled at negedge)
    task automatic edges_to_step(input int limit, output int n);
        n = 0;
        for (int i = 0; i < limit; i++) begin
            @(posedge clk);
            n++;
            @(negedge clk);
            if (step_en) return;
        end
        n = -1;
    endtask

    task automatic count_starts(input int cycles, output int n);
        n = 0;
        for (int i = 0; i < cycles; i++) begin
            @(negedge clk);
            if (start_pulse) n++;
        end
    endtask

    initial begin
        int n, m;
        // R1: reset state
        #1;
        chk(step_en == 1'b0 && start_pulse == 1'b0 && clk_out_en == 1'b0,
            "R1 outputs low in reset", {step_en, start_pulse, clk_out_en}, 0);
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        repeat (3) @(negedge clk);
        m = 0;
        for (int i = 0; i < 4; i++) begin
            @(negedge clk);
            if (step_en) m++;
        end
        chk(m == 4, "R1 default divide by 1", m, 4);
        chk(clk_out_en == 1'b0, "R1 default clock-out off", clk_out_en, 0);

        // R2 R3 R4 R7: ratio table, internal source
        for (int v = 0; v < NVEC; v++) begin
            write_cfg(1'b0, TV_DIV[v], 1'b0, 1'b0, TV_CO[v]);
            chk(clk_out_en == TV_CO[v], "R7 clock-out follows setup", clk_out_en, TV_CO[v]);
            chk(TV_EXP[v] == 1 || step_en == 1'b0, "R2 no step after write", step_en, 0);
            edges_to_step(3000, n);
            chk(n == TV_EXP[v], "R2 first step latency", n, TV_EXP[v]);
            edges_to_step(3000, n);
            chk(n == TV_EXP[v], TV_DIV[v] > 1024 ? "R4 clamped period" : "R3 step period",
                n, TV_EXP[v]);
        end

        // R2: mid-count rewrite restarts the count
        write_cfg(1'b0, 9, 1'b0, 1'b0, 1'b0);
        repeat (5) @(negedge clk);
        write_cfg(1'b0, 9, 1'b0, 1'b0, 1'b0);
        edges_to_step(100, n);
        chk(n == 9, "R2 rewrite clears count", n, 9);

        // R6 R7: external source, divide by 2, ext period 6 cycles
        ext_run = 1'b1;
        write_cfg(1'b1, 2, 1'b0, 1'b0, 1'b1);
        chk(clk_out_en == 1'b0, "R7 no drive with external source", clk_out_en, 0);
        edges_to_step(200, n);
        edges_to_step(200, n);
        chk(n == 12, "R6 external step period", n, 12);
        edges_to_step(200, n);
        chk(n == 12, "R6 external step period again", n, 12);
        ext_run = 1'b0;

        // R8: run-button start, sync ignored
        write_cfg(1'b0, 1, 1'b0, 1'b0, 1'b0);
        @(negedge clk); run_btn = 1'b1;
        @(negedge clk); run_btn = 1'b0;
        chk(start_pulse == 1'b1, "R8 run start", start_pulse, 1);
        @(negedge clk);
        chk(start_pulse == 1'b0, "R8 run pulse one cycle", start_pulse, 0);
        sync_in = 1'b1;
        count_starts(8, n);
        chk(n == 0, "R8 sync ignored in run mode", n, 0);
        sync_in = 1'b0;
        count_starts(8, n);
        chk(n == 0, "R8 sync fall ignored in run mode", n, 0);

        // R9: rising sync edge
        write_cfg(1'b0, 1, 1'b1, 1'b0, 1'b0);
        @(negedge clk); sync_in = 1'b1;
        repeat (2) @(negedge clk);
        chk(start_pulse == 1'b0, "R9 not before third edge", start_pulse, 0);
        @(negedge clk);
        chk(start_pulse == 1'b1, "R9 rising sync start", start_pulse, 1);
        @(negedge clk);
        chk(start_pulse == 1'b0, "R9 sync pulse one cycle", start_pulse, 0);
        sync_in = 1'b0;
        count_starts(8, n);
        chk(n == 0, "R9 falling edge ignored", n, 0);
        run_btn = 1'b1;
        @(negedge clk); run_btn = 1'b0;
        count_starts(4, n);
        chk(n == 0, "R9 run button ignored in sync mode", n, 0);

        // R10: falling sync edge
        sync_in = 1'b1;
        repeat (6) @(negedge clk);
        write_cfg(1'b0, 1, 1'b1, 1'b1, 1'b0);
        sync_in = 1'b0;
        repeat (2) @(negedge clk);
        chk(start_pulse == 1'b0, "R10 not before third edge", start_pulse, 0);
        @(negedge clk);
        chk(start_pulse == 1'b1, "R10 falling sync start", start_pulse, 1);
        sync_in = 1'b1;
        count_starts(8, n);
        chk(n == 0, "R10 rising edge ignored", n, 0);

        // R5: field 0 gives the long ratio
        write_cfg(1'b0, 0, 1'b0, 1'b0, 1'b0);
        m = 0;
        for (int i = 0; i < 120000; i++) begin
            @(negedge clk);
            if (step_en) m++;
        end
        chk(m == 0, "R5 no step in long ratio window", m, 0);

        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule